// File: doc/BRIEF.md
# Noise-Shaping Word-Length Requantizer

This block sits after an 8fs interpolation filter on one audio channel. It takes each wide two's-complement sample and cuts it down to a 16-, 18- or 20-bit output code. A two-bit mode picks the output length and whether first-order error-feedback noise shaping is applied. When shaping is off, the block rounds to nearest instead. An enable can add a small positive DC offset, scaled to the output length, and the result is then clipped to the output range.

The input `smp_in` is an `IN_W`-bit two's-complement value with full scale aligned to its MSB. One output LSB therefore equals 2^(IN_W-L) input LSBs, where L is the selected output length. The output is always presented on a 20-bit port, sign-extended from L bits. Each valid input gives exactly one valid output, one clock later. `IN_W` must be at least 21.

Top module: `rq_requant`

## Requirements
- R1: Mode decode, with `wl_mode[1]` as the first select and `wl_mode[0]` as the second: 2'b11 gives a 20-bit output with shaping off; 2'b10 gives an 18-bit output with shaping on (18-bit source); 2'b01 gives an 18-bit output with shaping on (16-bit source); 2'b00 gives a 16-bit output with shaping on.
- R2: `smp_out` carries the L-bit result sign-extended to 20 bits, so bits 19 down to L-1 are all equal.
- R3: `smp_out` and `smp_out_vld` update one clock after a cycle with `smp_in_vld` high. After a cycle with `smp_in_vld` low, `smp_out_vld` is low and `smp_out` keeps its value.
- R4: With shaping off, the block adds half an output LSB (2^(IN_W-L-1)) to the input and then takes the floor of the division by 2^(IN_W-L).
- R5: With shaping on, the block adds the stored residue to the input and then takes the floor. The new residue is the low IN_W-L bits of that sum, read as a non-negative number. The residue changes only on valid samples.
- R6: The residue is zero after reset. Each valid sample in the non-shaping mode loads zero into it.
- R7: When `dc_ofs_en` is high, 2^(L-7) output LSBs are added after requantizing: 512 for 16 bits, 2048 for 18 bits and 8192 for 20 bits. When it is low, nothing is added.
- R8: After the offset is added, the result saturates to the range -2^(L-1) to 2^(L-1)-1.
- R9: While reset is active, `smp_out` is zero and `smp_out_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside |
| smp_in | input | IN_W | Wide signed sample from the filter |
| smp_in_vld | input | 1 | Sample strobe |
| wl_mode | input | 2 | Word-length and shaping mode |
| dc_ofs_en | input | 1 | Adds the DC offset when high |
| smp_out | output | 20 | Requantized sample, sign-extended |
| smp_out_vld | output | 1 | Output strobe |

## Verification
The assertions assume that `wl_mode` is valid in the same cycle as its sample strobe. They also assume that the synchronized reset has been released before the first strobe. The range checks rely on the mode sampled alongside each strobe. The stimulus therefore changes the mode only together with a sample, and it waits several cycles after reset before sending anything. Gaps between strobes are inserted on purpose, so that the hold behaviour and the unchanged residue are both exercised.

// File: rtl/rq_pkg.sv
package rq_pkg;
  localparam int unsigned OUT_MAX = 20;

  typedef enum logic [1:0] {
    LEN16 = 2'd0,
    LEN18 = 2'd1,
    LEN20 = 2'd2
  } len_e;

  typedef struct packed {
    len_e len;
    logic shape;
  } cfg_t;

  function automatic int unsigned len_bits(len_e l);
    case (l)
      LEN16:   return 16;
      LEN18:   return 18;
      default: return 20;
    endcase
  endfunction
endpackage

// File: rtl/rq_mode_dec.sv
module rq_mode_dec
  import rq_pkg::*;
(
  input  logic [1:0] wl_mode,
  output cfg_t       cfg
);
  always_comb begin
    case (wl_mode)
      2'b11:   cfg = '{len: LEN20, shape: 1'b0};
      2'b10:   cfg = '{len: LEN18, shape: 1'b1};
      2'b01:   cfg = '{len: LEN18, shape: 1'b1};
      default: cfg = '{len: LEN16, shape: 1'b1};
    endcase
  end
endmodule

// File: rtl/rq_quant.sv
// Adds either the residue or half an output LSB, then floors by an arithmetic shift.
module rq_quant #(
  parameter int unsigned IN_W = 24,
  parameter int unsigned SW   = 5
) (
  input  logic signed [IN_W-1:0] din,
  input  logic        [IN_W-1:0] resid,
  input  logic                   shape,
  input  logic        [SW-1:0]   shift,
  output logic signed [IN_W:0]   q,
  output logic        [IN_W-1:0] resid_nxt
);
  localparam int unsigned VW = IN_W + 1;

  logic signed [VW-1:0]   v;
  logic        [VW-1:0]   addend;
  logic        [IN_W-1:0] mask;

  always_comb begin
    if (shape) addend = {1'b0, resid};
    else       addend = VW'(1) << (shift - SW'(1));
    v         = signed'({din[IN_W-1], din} + addend);
    q         = v >>> shift;
    mask      = (IN_W'(1) << shift) - IN_W'(1);
    resid_nxt = v[IN_W-1:0] & mask;
  end
endmodule

// File: rtl/rq_clip.sv
// Adds the length-scaled offset, then saturates to the selected length.
module rq_clip
  import rq_pkg::*;
#(
  parameter int unsigned QW    = 25,
  parameter int unsigned OUT_W = 20
) (
  input  logic signed [QW-1:0]    q,
  input  len_e                    len,
  input  logic                    ofs_en,
  output logic signed [OUT_W-1:0] y
);
  localparam int unsigned SUMW = QW + 1;

  logic signed [SUMW-1:0] sum, lim_hi, lim_lo, ofs, sat;
  int unsigned            l;

  always_comb begin
    l      = len_bits(len);
    lim_hi = signed'((SUMW'(1) << (l - 1)) - SUMW'(1));
    lim_lo = -signed'(SUMW'(1) << (l - 1));
    ofs    = ofs_en ? signed'(SUMW'(1) << (l - 7)) : '0;
    sum    = SUMW'(q) + ofs;
    if (sum > lim_hi)      sat = lim_hi;
    else if (sum < lim_lo) sat = lim_lo;
    else                   sat = sum;
    y = sat[OUT_W-1:0];
  end
endmodule

// File: rtl/rq_requant.sv
module rq_requant
  import rq_pkg::*;
#(
  parameter int unsigned IN_W  = 24,
  parameter int unsigned OUT_W = OUT_MAX
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [IN_W-1:0]  smp_in,
  input  logic                    smp_in_vld,
  input  logic [1:0]              wl_mode,
  input  logic                    dc_ofs_en,
  output logic signed [OUT_W-1:0] smp_out,
  output logic                    smp_out_vld
);
  localparam int unsigned SW = $clog2(IN_W + 1);

  // reset synchronizer: asynchronous assert, synchronous release
  logic rst_meta, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  cfg_t                    cfg;
  logic        [SW-1:0]    shift;
  logic signed [IN_W:0]    q;
  logic        [IN_W-1:0]  resid_q, resid_d, resid_nxt;
  logic signed [OUT_W-1:0] y, out_d, out_q;
  logic                    vld_q;

  rq_mode_dec u_dec (.wl_mode(wl_mode), .cfg(cfg));

  always_comb shift = SW'(IN_W - len_bits(cfg.len));

  rq_quant #(.IN_W(IN_W), .SW(SW)) u_quant (
    .din(smp_in), .resid(resid_q), .shape(cfg.shape), .shift(shift),
    .q(q), .resid_nxt(resid_nxt)
  );

  rq_clip #(.QW(IN_W + 1), .OUT_W(OUT_W)) u_clip (
    .q(q), .len(cfg.len), .ofs_en(dc_ofs_en), .y(y)
  );

  // next state
  always_comb begin
    out_d   = out_q;
    resid_d = resid_q;
    if (smp_in_vld) begin
      out_d   = y;
      resid_d = cfg.shape ? resid_nxt : '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      out_q   <= '0;
      resid_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= smp_in_vld;
      if (smp_in_vld) begin
        out_q   <= out_d;
        resid_q <= resid_d;
      end
    end
  end

  assign smp_out     = out_q;
  assign smp_out_vld = vld_q;
endmodule

// File: rtl/rq_requant_chk.sv
module rq_requant_chk #(
  parameter int unsigned OUT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_in_vld,
  input logic [1:0]       wl_mode,
  input logic [OUT_W-1:0] smp_out,
  input logic             smp_out_vld
);
  // R3
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_in_vld |=> smp_out_vld);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_in_vld |=> (!smp_out_vld && $stable(smp_out)));

  // R2
  len16_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_in_vld && wl_mode == 2'b00) |=>
      ($countones(smp_out[OUT_W-1:15]) == 0 || $countones(smp_out[OUT_W-1:15]) == OUT_W - 15));

  // R2
  len18_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_in_vld && (wl_mode == 2'b01 || wl_mode == 2'b10)) |=>
      ($countones(smp_out[OUT_W-1:17]) == 0 || $countones(smp_out[OUT_W-1:17]) == OUT_W - 17));
endmodule

bind rq_requant rq_requant_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_sn), .smp_in_vld(smp_in_vld), .wl_mode(wl_mode),
  .smp_out(smp_out), .smp_out_vld(smp_out_vld)
);

// File: tb/sim_rq_requant.sv
`timescale 1ns/1ps
module sim_rq_requant;
  localparam int IN_W = 24;

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic signed [IN_W-1:0] smp_in;
  logic                   smp_in_vld;
  logic [1:0]             wl_mode;
  logic                   dc_ofs_en;
  logic signed [19:0]     smp_out;
  logic                   smp_out_vld;

  int total = 0, bad = 0;
  bit done = 0;
  longint model_err = 0;
  longint exp_q[$];
  string  tag_q[$];

  always #5 clk = ~clk;

  rq_requant #(.IN_W(IN_W)) u0 (.*);

  function automatic longint model(longint din, logic [1:0] m, bit ofs, ref longint err);
    int     l  = (m == 2'b11) ? 20 : (m == 2'b00) ? 16 : 18;
    bit     sh = (m != 2'b11);
    int     s  = IN_W - l;
    longint v, q, e, r, hi, lo;
    v  = din + (sh ? err : (longint'(1) <<< (s - 1)));
    q  = v >>> s;
    e  = v - (q <<< s);
    r  = q + (ofs ? (longint'(1) <<< (l - 7)) : 0);
    hi = (longint'(1) <<< (l - 1)) - 1;
    lo = -(longint'(1) <<< (l - 1));
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    err = sh ? e : 0;
    return r;
  endfunction

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic send(longint d, logic [1:0] m, bit ofs, string req);
    @(negedge clk);
    smp_in     = IN_W'(d);
    smp_in_vld = 1'b1;
    wl_mode    = m;
    dc_ofs_en  = ofs;
    exp_q.push_back(model(d, m, ofs, model_err));
    tag_q.push_back(req);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_in_vld = 1'b0;
      smp_in     = '1;
      wl_mode    = 2'b00;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (smp_out_vld) begin
      if (exp_q.size() == 0) check("R3", 1, 0);
      else check(tag_q.pop_front(), longint'(smp_out), exp_q.pop_front());
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint held;
    rst_n = 1'b0; smp_in = '0; smp_in_vld = 1'b0; wl_mode = 2'b00; dc_ofs_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", longint'(smp_out), 0);
    check("R9", longint'(smp_out_vld), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(4);

    // R4 rounding, 20-bit, shaping off (half LSB = 8)
    send(8, 2'b11, 0, "R4");
    send(7, 2'b11, 0, "R4");
    send(-8, 2'b11, 0, "R4");
    send(-9, 2'b11, 0, "R4");
    send(24'h123456, 2'b11, 0, "R1");
    // R7 offsets
    send(0, 2'b11, 1, "R7");
    send(0, 2'b01, 1, "R7");
    send(0, 2'b00, 1, "R7");
    send(0, 2'b00, 0, "R7");
    // R8 saturation
    send(24'sh7FFFFF, 2'b11, 1, "R8");
    send(24'sh7FFFF0, 2'b10, 1, "R8");
    send(-(64'sd1 <<< 23), 2'b00, 1, "R8");
    idle(3);
    // R3 hold with no strobe
    held = longint'(smp_out);
    check("R3", longint'(smp_out_vld), 0);
    check("R3", longint'(smp_out), held);

    // R6 residue cleared by non-shaping mode, then R5 accumulation in 16-bit mode
    send(1000, 2'b11, 0, "R6");
    for (int i = 0; i < 6; i++) send(64, 2'b00, 0, "R5");
    idle(2);
    // residue held across gap
    for (int i = 0; i < 4; i++) send(96, 2'b00, 0, "R5");
    for (int i = 0; i < 5; i++) send(-300 + i * 77, 2'b10, 0, "R5");
    for (int i = 0; i < 5; i++) send(1234 * i - 2000, 2'b01, 1, "R1");
    for (int i = 0; i < 4; i++) send(-5 * i - 1, 2'b00, 0, "R2");
    idle(3);

    // R6 residue cleared by reset
    send(200, 2'b00, 0, "R6");
    idle(2);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R9", longint'(smp_out), 0);
    check("R9", longint'(smp_out_vld), 0);
    rst_n = 1'b1;
    model_err = 0;
    idle(4);
    send(200, 2'b00, 0, "R6");
    send(200, 2'b00, 0, "R6");
    idle(3);
    check("R3", exp_q.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule